// File: doc/BRIEF.md
# Interrupt Delivery Gate

This block sits between an interrupt controller and the event-injection slot of a processor core. Each time the core is about to be entered, the environment raises a one-cycle entry request. The gate then decides, in a single registered step, one of four things. It can leave an already occupied slot alone, or re-inject an event whose delivery was cut short. It can take a fresh interrupt from the controller, or defer and ask to be notified when the core can accept one.

Re-injection of an interrupted event always wins over a new interrupt. A new interrupt is taken only when the core has interrupts enabled and no blocking condition is active. In that case the gate pulses an acknowledge to the controller and writes the controller's vector into the slot, marked as an external interrupt. When delivery is not possible, the request is not lost. The gate raises a level-type window enable, which stays on until the window-exit event arrives.

Top module: `irq_entry_gate`

## Requirements
- R1: After a synchronous active-low reset, `slot_wr`, `slot_ec_wr`, `ack` and `win_en` are 0, and every slot field output is 0.
- R2: When an entry request sees `slot_busy` = 1, no slot write and no acknowledge occur. `win_en` becomes 1 if `irq_pending` is 1 and otherwise keeps its value.
- R3: When an entry request sees `slot_busy` = 0 and `redo_valid` = 1, the slot is written with `redo_vector`, `redo_type` and `redo_len`, with no acknowledge. `win_en` becomes 1 if `irq_pending` is also 1.
- R4: During a re-injection, `slot_ec_wr` equals `redo_has_ec`. `slot_ec` carries `redo_ec` when `redo_has_ec` is 1 and is 0 otherwise.
- R5: An entry request with `slot_busy` = 0, `redo_valid` = 0 and `irq_pending` = 0 produces no write and no acknowledge, and leaves `win_en` unchanged.
- R6: An entry request with `slot_busy` = 0, `redo_valid` = 0, `irq_pending` = 1, `core_ie` = 1 and `block_bits` = 0 pulses `ack`. In the same cycle it writes `irq_vector` to the slot with `slot_type` = 0 (external interrupt), `slot_len` = 0 and `slot_ec_wr` = 0.
- R7: Under the R6 conditions but with `core_ie` = 0 or a nonzero `block_bits`, no write and no acknowledge occur, and `win_en` becomes 1.
- R8: A `win_exit` pulse clears `win_en` on the next edge, unless the same edge also sets it through R2, R3 or R7.
- R9: All slot and acknowledge outputs appear on the clock edge that samples the entry request, last exactly one cycle, and stay 0 in cycles without a preceding request. Slot field outputs are 0 whenever `slot_wr` is 0.
- R10: A single entry never yields both an acknowledge and a re-injection; `ack` = 1 implies an external-type slot write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| entry_req | input | 1 | One-cycle request to decide before core entry |
| irq_pending | input | 1 | Controller has a deliverable interrupt |
| irq_vector | input | 8 | Vector the controller returns on acknowledge |
| slot_busy | input | 1 | Injection slot already holds a valid event |
| redo_valid | input | 1 | An interrupted delivery must be re-injected |
| redo_vector | input | 8 | Vector of the interrupted event |
| redo_type | input | 3 | Event type of the interrupted event |
| redo_has_ec | input | 1 | Interrupted event carries an error code |
| redo_ec | input | 32 | Error code of the interrupted event |
| redo_len | input | 4 | Saved instruction length |
| core_ie | input | 1 | Core interrupt-enable flag |
| block_bits | input | 2 | Interruptibility blocking field, zero when unblocked |
| win_exit | input | 1 | Window-exit event occurred |
| slot_wr | output | 1 | Write pulse to the injection slot (valid bit) |
| slot_vector | output | 8 | Vector written to the slot |
| slot_type | output | 3 | Event type written to the slot |
| slot_len | output | 4 | Instruction length written to the slot |
| slot_ec_wr | output | 1 | Error code is written with this slot write |
| slot_ec | output | 32 | Error code written to the slot |
| ack | output | 1 | One-cycle acknowledge to the controller |
| win_en | output | 1 | Request-window enable |

## Verification
The hardest state to reach is an entry where a re-injection and a deliverable new interrupt are present together. The re-injection must win, the acknowledge must stay low, and the window must still open. A close second is a window-exit pulse that lands on the same edge as a decision that reopens the window. The random stimulus biases pending, re-injection, enable and exit flags so that these overlaps occur often. Directed steps then force each overlap once, including both blocking reasons and re-injection with and without an error code.

// File: rtl/igate_pkg.sv
// Package: shared widths, decision kinds and event type codes for the gate.
// Assumes: the external-interrupt event type is encoded as 0.
package igate_pkg;
    localparam int unsigned TYPE_W = 3;
    localparam logic [TYPE_W-1:0] EVT_EXTERNAL = '0;

    typedef enum logic [2:0] {
        DK_NONE,   // no request, or nothing to do
        DK_HOLD,   // slot already occupied
        DK_REDO,   // re-inject interrupted event
        DK_NEW,    // deliver new interrupt
        DK_WAIT    // delivery blocked, open window
    } decide_t;
endpackage

// File: rtl/igate_decide.sv
// Module: combinational priority decision for one entry request.
// Assumes: inputs are stable in the cycle entry_req is high.
module igate_decide #(
    parameter int unsigned BLK_W = 2
) (
    input  logic             entry_req,
    input  logic             irq_pending,
    input  logic             slot_busy,
    input  logic             redo_valid,
    input  logic             core_ie,
    input  logic [BLK_W-1:0] block_bits,
    output igate_pkg::decide_t kind,
    output logic             win_set
);
    import igate_pkg::*;

    logic can_deliver;
    assign can_deliver = core_ie && (block_bits == '0);

    // Purpose: pick the single action for this entry, re-injection before new.
    always_comb begin
        kind = DK_NONE;
        if (entry_req) begin
            if (slot_busy)         kind = DK_HOLD;
            else if (redo_valid)   kind = DK_REDO;
            else if (!irq_pending) kind = DK_NONE;
            else if (can_deliver)  kind = DK_NEW;
            else                   kind = DK_WAIT;
        end
    end

    // Purpose: request a window whenever a pending interrupt is left waiting.
    always_comb begin
        win_set = (kind == DK_WAIT) ||
                  (((kind == DK_HOLD) || (kind == DK_REDO)) && irq_pending);
    end
endmodule

// File: rtl/igate_slot_reg.sv
// Module: registers the slot write fields and the acknowledge pulse.
// Assumes: kind is DK_NONE outside entry cycles; fields read 0 when not written.
module igate_slot_reg #(
    parameter int unsigned VEC_W = 8,
    parameter int unsigned EC_W  = 32,
    parameter int unsigned LEN_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  igate_pkg::decide_t       kind,
    input  logic [VEC_W-1:0]         irq_vector,
    input  logic [VEC_W-1:0]         redo_vector,
    input  logic [igate_pkg::TYPE_W-1:0] redo_type,
    input  logic                     redo_has_ec,
    input  logic [EC_W-1:0]          redo_ec,
    input  logic [LEN_W-1:0]         redo_len,
    output logic                     slot_wr,
    output logic [VEC_W-1:0]         slot_vector,
    output logic [igate_pkg::TYPE_W-1:0] slot_type,
    output logic [LEN_W-1:0]         slot_len,
    output logic                     slot_ec_wr,
    output logic [EC_W-1:0]          slot_ec,
    output logic                     ack
);
    import igate_pkg::*;

    // Purpose: produce one-cycle slot write and acknowledge from the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_wr     <= 1'b0;
            slot_vector <= '0;
            slot_type   <= '0;
            slot_len    <= '0;
            slot_ec_wr  <= 1'b0;
            slot_ec     <= '0;
            ack         <= 1'b0;
        end else begin
            slot_wr     <= 1'b0;
            slot_vector <= '0;
            slot_type   <= '0;
            slot_len    <= '0;
            slot_ec_wr  <= 1'b0;
            slot_ec     <= '0;
            ack         <= 1'b0;
            case (kind)
                DK_REDO: begin
                    slot_wr     <= 1'b1;
                    slot_vector <= redo_vector;
                    slot_type   <= redo_type;
                    slot_len    <= redo_len;
                    slot_ec_wr  <= redo_has_ec;
                    slot_ec     <= redo_has_ec ? redo_ec : '0;
                end
                DK_NEW: begin
                    slot_wr     <= 1'b1;
                    slot_vector <= irq_vector;
                    slot_type   <= EVT_EXTERNAL;
                    ack         <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/igate_window.sv
// Module: holds the request-window enable between set and exit events.
// Assumes: a set and an exit on the same edge leave the window open.
module igate_window (
    input  logic clk,
    input  logic rst_n,
    input  logic win_set,
    input  logic win_exit,
    output logic win_en
);
    // Purpose: set on a deferred request, clear on window exit.
    always_ff @(posedge clk) begin
        if (!rst_n)        win_en <= 1'b0;
        else if (win_set)  win_en <= 1'b1;
        else if (win_exit) win_en <= 1'b0;
    end
endmodule

// File: rtl/irq_entry_gate.sv
// Module: top of the interrupt delivery gate; decides per entry request
// whether to hold, re-inject, deliver new, or defer with a window.
// Assumes: entry_req is a single-cycle strobe; irq_vector is valid with irq_pending.
module irq_entry_gate #(
    parameter int unsigned VEC_W = 8,
    parameter int unsigned EC_W  = 32,
    parameter int unsigned LEN_W = 4,
    parameter int unsigned BLK_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 entry_req,
    input  logic                 irq_pending,
    input  logic [VEC_W-1:0]     irq_vector,
    input  logic                 slot_busy,
    input  logic                 redo_valid,
    input  logic [VEC_W-1:0]     redo_vector,
    input  logic [2:0]           redo_type,
    input  logic                 redo_has_ec,
    input  logic [EC_W-1:0]      redo_ec,
    input  logic [LEN_W-1:0]     redo_len,
    input  logic                 core_ie,
    input  logic [BLK_W-1:0]     block_bits,
    input  logic                 win_exit,
    output logic                 slot_wr,
    output logic [VEC_W-1:0]     slot_vector,
    output logic [2:0]           slot_type,
    output logic [LEN_W-1:0]     slot_len,
    output logic                 slot_ec_wr,
    output logic [EC_W-1:0]      slot_ec,
    output logic                 ack,
    output logic                 win_en
);
    igate_pkg::decide_t kind;
    logic               win_set;

    igate_decide #(.BLK_W(BLK_W)) u_decide (
        .entry_req  (entry_req),
        .irq_pending(irq_pending),
        .slot_busy  (slot_busy),
        .redo_valid (redo_valid),
        .core_ie    (core_ie),
        .block_bits (block_bits),
        .kind       (kind),
        .win_set    (win_set)
    );

    igate_slot_reg #(.VEC_W(VEC_W), .EC_W(EC_W), .LEN_W(LEN_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .irq_vector (irq_vector),
        .redo_vector(redo_vector),
        .redo_type  (redo_type),
        .redo_has_ec(redo_has_ec),
        .redo_ec    (redo_ec),
        .redo_len   (redo_len),
        .slot_wr    (slot_wr),
        .slot_vector(slot_vector),
        .slot_type  (slot_type),
        .slot_len   (slot_len),
        .slot_ec_wr (slot_ec_wr),
        .slot_ec    (slot_ec),
        .ack        (ack)
    );

    igate_window u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_set (win_set),
        .win_exit(win_exit),
        .win_en  (win_en)
    );
endmodule

// File: rtl/igate_checker.sv
// Module: temporal checks on the gate's ports, bound into the top.
// Assumes: same clock and synchronous active-low reset as the gate.
module igate_checker #(
    parameter int unsigned BLK_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             entry_req,
    input logic             irq_pending,
    input logic             slot_busy,
    input logic             redo_valid,
    input logic             redo_has_ec,
    input logic             core_ie,
    input logic [BLK_W-1:0] block_bits,
    input logic             win_exit,
    input logic             slot_wr,
    input logic [2:0]       slot_type,
    input logic             slot_ec_wr,
    input logic             ack,
    input logic             win_en
);
    p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_req && slot_busy) |=> (!slot_wr && !ack));

    p_redo_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_req && !slot_busy && redo_valid) |=> (slot_wr && !ack));

    p_ec_follows_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_req && !slot_busy && redo_valid) |=> (slot_ec_wr == $past(redo_has_ec)));

    p_ack_external_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (slot_wr && slot_type == 3'd0));

    p_blocked_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_req && !slot_busy && !redo_valid && irq_pending &&
         !(core_ie && block_bits == '0)) |=> (win_en && !ack && !slot_wr));

    p_exit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_exit && !entry_req) |=> !win_en);

    p_needs_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_req |=> (!slot_wr && !ack));

    p_ec_only_with_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_ec_wr |-> (slot_wr && !ack));
endmodule

bind irq_entry_gate igate_checker #(.BLK_W(BLK_W)) i_igate_checker (.*);

// File: tb/test_irq_entry_gate.sv
// Bench: random plus directed entries against a reference model of the gate.
module test_irq_entry_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_req = 0, irq_pending = 0, slot_busy = 0, redo_valid = 0;
    logic [7:0]  irq_vector = 0, redo_vector = 0;
    logic [2:0]  redo_type = 0;
    logic        redo_has_ec = 0;
    logic [31:0] redo_ec = 0;
    logic [3:0]  redo_len = 0;
    logic        core_ie = 0;
    logic [1:0]  block_bits = 0;
    logic        win_exit = 0;
    logic        slot_wr, slot_ec_wr, ack, win_en;
    logic [7:0]  slot_vector;
    logic [2:0]  slot_type;
    logic [3:0]  slot_len;
    logic [31:0] slot_ec;

    int total = 0, bad = 0;
    logic m_win = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_entry_gate i_irq_entry_gate (.*);

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Apply one cycle of inputs at negedge, compare outputs at the next negedge.
    task automatic step(string tag);
        logic e_wr, e_ecw, e_ack, set;
        logic [7:0] e_vec; logic [2:0] e_typ; logic [3:0] e_len; logic [31:0] e_ec;
        e_wr = 0; e_ecw = 0; e_ack = 0; set = 0; e_vec = 0; e_typ = 0; e_len = 0; e_ec = 0;
        if (entry_req) begin
            if (slot_busy) set = irq_pending;
            else if (redo_valid) begin
                e_wr = 1; e_vec = redo_vector; e_typ = redo_type; e_len = redo_len;
                e_ecw = redo_has_ec; e_ec = redo_has_ec ? redo_ec : 32'd0;
                set = irq_pending;
            end else if (irq_pending) begin
                if (core_ie && block_bits == 2'd0) begin
                    e_wr = 1; e_ack = 1; e_vec = irq_vector;
                end else set = 1;
            end
        end
        if (set) m_win = 1; else if (win_exit) m_win = 0;
        @(negedge clk);
        check({tag, " wr"},  slot_wr, e_wr);
        check({tag, " ack"}, ack, e_ack);
        check({tag, " vec"}, slot_vector, e_vec);
        check({tag, " typ"}, slot_type, e_typ);
        check({tag, " len"}, slot_len, e_len);
        check({tag, " ecw"}, slot_ec_wr, e_ecw);
        check({tag, " ec"},  slot_ec, e_ec);
        check({tag, " win"}, win_en, m_win);
    endtask

    task automatic setin(logic req, logic pend, logic busy, logic redo,
                         logic hasec, logic ie, logic [1:0] blk, logic ex);
        entry_req = req; irq_pending = pend; slot_busy = busy; redo_valid = redo;
        redo_has_ec = hasec; core_ie = ie; block_bits = blk; win_exit = ex;
        irq_vector = 8'h41; redo_vector = 8'h0e; redo_type = 3'd3;
        redo_ec = 32'hdead_0001; redo_len = 4'd5;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 wr", slot_wr, 0); check("R1 ack", ack, 0);
        check("R1 win", win_en, 0); check("R1 vec", slot_vector, 0);
        // R5: idle entry
        setin(1, 0, 0, 0, 0, 1, 0, 0); step("R5 idle");
        // R6: new delivery
        setin(1, 1, 0, 0, 0, 1, 0, 0); step("R6 deliver");
        // R9: no request, nothing written
        setin(0, 1, 0, 1, 1, 1, 0, 0); step("R9 norequest");
        // R7: blocked by enable, then by blocking field
        setin(1, 1, 0, 0, 0, 0, 0, 0); step("R7 ie_off");
        setin(0, 0, 0, 0, 0, 0, 0, 1); step("R8 exit");
        setin(1, 1, 0, 0, 0, 1, 2'd2, 0); step("R7 blocked");
        // R8: exit on same edge as set keeps window
        setin(1, 1, 0, 0, 0, 1, 2'd1, 1); step("R8 exit_with_set");
        setin(0, 0, 0, 0, 0, 0, 0, 1); step("R8 exit2");
        // R2: occupied slot with and without pending
        setin(1, 1, 1, 1, 0, 1, 0, 0); step("R2 busy_pend");
        setin(0, 0, 0, 0, 0, 0, 0, 1); step("R8 exit3");
        setin(1, 0, 1, 0, 0, 1, 0, 0); step("R2 busy_idle");
        // R3/R4/R10: re-injection with pending new interrupt, with and without code
        setin(1, 1, 0, 1, 1, 1, 0, 0); step("R3 R10 redo_pend_ec");
        setin(1, 0, 0, 1, 0, 1, 0, 1); step("R4 redo_noec");
        // random mix
        for (int i = 0; i < 400; i++) begin
            entry_req   = ($urandom % 10) < 8;
            irq_pending = ($urandom % 10) < 7;
            slot_busy   = ($urandom % 4) == 0;
            redo_valid  = ($urandom % 10) < 3;
            redo_has_ec = $urandom % 2;
            core_ie     = ($urandom % 10) < 7;
            block_bits  = (($urandom % 10) < 6) ? 2'd0 : 2'($urandom);
            win_exit    = ($urandom % 5) == 0;
            irq_vector  = 8'($urandom); redo_vector = 8'($urandom);
            redo_type   = 3'($urandom); redo_ec = $urandom; redo_len = 4'($urandom);
            step("R3 R6 R7 R8 random");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule